// File: doc/BRIEF.md
# Reservation Station Pool with Broadcast Wakeup and Oldest-First Dispatch

This block holds a small pool of waiting instructions for one execution unit in an out-of-order core. Instructions reach it already renamed. Each source operand comes either as a value or as the tag of the station that will produce it. Tag zero is reserved and means "value present". The pool has no separate ready bits: an operand counts as available exactly when its tag field is zero. Each pool entry has a fixed tag of its own, equal to `BASE_TAG` plus the entry index. That tag is handed back to the issue stage so that it can rename later consumers.

A single result broadcast bus carries a valid strobe, a producer tag and the result value. Every pending entry compares its waiting tags with the bus. On a match the entry takes the value and clears the tag. An instruction whose operands are all present becomes a dispatch candidate on the following cycle. Among the candidates, the one issued earliest goes to the execution unit. The executing entry stays occupied until the unit broadcasts a result under that entry's own tag, and the slot is then released.

Both data interfaces use valid/ready. On the issue side, `iss_ready` is high whenever a slot is free and does not depend on `iss_valid`. A transfer takes place on a rising edge with both signals high. When the pool is full, the upstream stage must hold its instruction and wait. On the dispatch side, once `disp_valid` is high the offered instruction and its payload stay fixed until `disp_ready` accepts them, even if an older entry becomes ready in the meantime. The broadcast bus has no back-pressure.

Top module: `rs_pool`

## Requirements
- R1: After reset every entry is free: `iss_ready`=1, `full`=0, `disp_valid`=0.
- R2: An issue transfer fills the lowest-index free entry. `iss_tag` shows that entry's tag (`BASE_TAG`+index) during the transfer cycle.
- R3: With every entry occupied, `full`=1 and `iss_ready`=0. An `iss_valid` offered in that state allocates nothing, and that instruction is never dispatched.
- R4: A source is present only when its tag is 0. An entry is offered for dispatch only while both of its tags are 0 and it has not yet been dispatched.
- R5: A broadcast whose nonzero tag equals a waiting source tag stores the bus value in that source and clears its tag. The entry can be offered on the first cycle after the broadcast edge.
- R6: If an issue transfer and a broadcast happen in the same cycle and the bus tag equals a nonzero incoming source tag, the entry stores the bus value, not the tag.
- R7: When several entries are ready, the one issued first is offered, whatever its index. At most one entry is offered at a time.
- R8: While `disp_valid`=1 and `disp_ready`=0, the offered tag and payload stay unchanged on the next cycle. After an accepted dispatch, that entry is not offered again.
- R9: A broadcast carrying an entry's own tag frees that entry only if it is executing, and the slot can be reused from the next cycle. The same broadcast leaves an entry that is still waiting occupied.
- R10: A broadcast whose tag matches no waiting source leaves every waiting source unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue stage offers an instruction |
| iss_ready | output | 1 | A free entry exists |
| iss_op | input | OP_W | Operation code |
| iss_a_val | input | DATA_W | Source A value (used when its tag is 0) |
| iss_a_tag | input | TAG_W | Source A producer tag, 0 = present |
| iss_b_val | input | DATA_W | Source B value (used when its tag is 0) |
| iss_b_tag | input | TAG_W | Source B producer tag, 0 = present |
| iss_imm | input | IMM_W | Address offset or immediate, carried unchanged |
| iss_tag | output | TAG_W | Tag of the entry that a transfer would fill |
| full | output | 1 | All entries occupied |
| bc_valid | input | 1 | Result broadcast strobe |
| bc_tag | input | TAG_W | Producer tag of the broadcast result |
| bc_data | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | A ready instruction is offered |
| disp_ready | input | 1 | Execution unit accepts the offer |
| disp_op | output | OP_W | Offered operation code |
| disp_a | output | DATA_W | Offered source A value |
| disp_b | output | DATA_W | Offered source B value |
| disp_imm | output | IMM_W | Offered immediate |
| disp_tag | output | TAG_W | Tag the unit returns with its result |

## Verification
Several properties are checked on every cycle: tag capture on a broadcast match and on an issue that coincides with a broadcast, the move to pending after allocation, release on the entry's own writeback tag, at most one grant and only to a ready entry, and payload hold and non-repetition at the dispatch port. Other behaviour can only be shown by the bench's scenarios. These are the oldest-first choice when a lower index is younger, the lock of an offered entry against a later-waking older one, slot reuse order, refusal of issue when the pool is full, and the absence of any effect from unrelated broadcasts, all observed at the ports.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_PEND = 2'd1,
    SLOT_EXEC = 2'd2
  } slot_state_e;

endpackage

// File: rtl/rs_alloc.sv
module rs_alloc #(
  parameter int N_ENT = 4,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic [N_ENT-1:0] busy_i,
  output logic [N_ENT-1:0] pick_oh_o,
  output logic [IDX_W-1:0] pick_idx_o,
  output logic             any_free_o
);

  always_comb begin
    pick_oh_o  = '0;
    pick_idx_o = '0;
    any_free_o = 1'b0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!busy_i[i]) begin
        pick_oh_o  = '0;
        pick_oh_o[i] = 1'b1;
        pick_idx_o = IDX_W'(i);
        any_free_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int OP_W   = 4,
  parameter int IMM_W  = 16,
  parameter logic [TAG_W-1:0] MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [OP_W-1:0]   in_op,
  input  logic [DATA_W-1:0] in_a_val,
  input  logic [TAG_W-1:0]  in_a_tag,
  input  logic [DATA_W-1:0] in_b_val,
  input  logic [TAG_W-1:0]  in_b_tag,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  input  logic              launch_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] a_val_o,
  output logic [DATA_W-1:0] b_val_o,
  output logic [IMM_W-1:0]  imm_o
);

  slot_state_e       st_q;
  logic [OP_W-1:0]   op_q;
  logic [IMM_W-1:0]  imm_q;
  logic [DATA_W-1:0] a_val_q, b_val_q;
  logic [TAG_W-1:0]  a_tag_q, b_tag_q;

  logic in_a_hit, in_b_hit, a_hit, b_hit, wb_hit;

  assign in_a_hit = bc_valid && (in_a_tag != '0) && (in_a_tag == bc_tag);
  assign in_b_hit = bc_valid && (in_b_tag != '0) && (in_b_tag == bc_tag);
  assign a_hit    = bc_valid && (a_tag_q != '0) && (a_tag_q == bc_tag);
  assign b_hit    = bc_valid && (b_tag_q != '0) && (b_tag_q == bc_tag);
  assign wb_hit   = bc_valid && (bc_tag == MY_TAG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SLOT_FREE;
      op_q    <= '0;
      imm_q   <= '0;
      a_val_q <= '0;
      b_val_q <= '0;
      a_tag_q <= '0;
      b_tag_q <= '0;
    end else begin
      unique case (st_q)
        SLOT_FREE: begin
          if (alloc_i) begin
            st_q  <= SLOT_PEND;
            op_q  <= in_op;
            imm_q <= in_imm;
            if (in_a_hit) begin
              a_val_q <= bc_data;
              a_tag_q <= '0;
            end else begin
              a_val_q <= in_a_val;
              a_tag_q <= in_a_tag;
            end
            if (in_b_hit) begin
              b_val_q <= bc_data;
              b_tag_q <= '0;
            end else begin
              b_val_q <= in_b_val;
              b_tag_q <= in_b_tag;
            end
          end
        end
        SLOT_PEND: begin
          if (a_hit) begin
            a_val_q <= bc_data;
            a_tag_q <= '0;
          end
          if (b_hit) begin
            b_val_q <= bc_data;
            b_tag_q <= '0;
          end
          if (launch_i) st_q <= SLOT_EXEC;
        end
        SLOT_EXEC: begin
          if (wb_hit) st_q <= SLOT_FREE;
        end
        default: st_q <= SLOT_FREE;
      endcase
    end
  end

  assign busy_o  = (st_q != SLOT_FREE);
  assign ready_o = (st_q == SLOT_PEND) && (a_tag_q == '0) && (b_tag_q == '0);
  assign op_o    = op_q;
  assign a_val_o = a_val_q;
  assign b_val_o = b_val_q;
  assign imm_o   = imm_q;

  assert_alloc_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |=> (st_q == SLOT_PEND));

  assert_launch_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |-> (st_q == SLOT_PEND && a_tag_q == '0 && b_tag_q == '0));

  assert_wake_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SLOT_PEND && a_tag_q != '0 && bc_valid && bc_tag == a_tag_q)
      |=> (a_tag_q == '0 && a_val_q == $past(bc_data)));

  assert_wake_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SLOT_PEND && b_tag_q != '0 && bc_valid && bc_tag == b_tag_q)
      |=> (b_tag_q == '0 && b_val_q == $past(bc_data)));

  assert_issue_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && in_a_tag != '0 && bc_valid && bc_tag == in_a_tag)
      |=> (a_tag_q == '0 && a_val_q == $past(bc_data)));

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SLOT_EXEC && bc_valid && bc_tag == MY_TAG) |=> (st_q == SLOT_FREE));

  assert_waiter_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SLOT_PEND) |=> (st_q != SLOT_FREE));

endmodule

// File: rtl/rs_age_sel.sv
module rs_age_sel #(
  parameter int N_ENT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ENT-1:0] alloc_oh_i,
  input  logic [N_ENT-1:0] ready_i,
  input  logic             disp_ready_i,
  output logic [N_ENT-1:0] grant_o,
  output logic             any_o
);

  // older_q[j][i] set: entry j was issued before entry i
  logic [N_ENT-1:0] older_q [N_ENT];
  logic [N_ENT-1:0] oldest;
  logic             lock_q;
  logic [N_ENT-1:0] lock_oh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < N_ENT; j++) older_q[j] <= '0;
      lock_q    <= 1'b0;
      lock_oh_q <= '0;
    end else begin
      for (int i = 0; i < N_ENT; i++) begin
        if (alloc_oh_i[i]) begin
          older_q[i] <= '0;
          for (int j = 0; j < N_ENT; j++) begin
            if (j != i) older_q[j][i] <= 1'b1;
          end
        end
      end
      lock_q    <= any_o && !disp_ready_i;
      lock_oh_q <= grant_o;
    end
  end

  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < N_ENT; j++) begin
        if (j != i && ready_i[j] && older_q[j][i]) blocked = 1'b1;
      end
      oldest[i] = ready_i[i] && !blocked;
    end
  end

  assign grant_o = lock_q ? lock_oh_q : oldest;
  assign any_o   = |grant_o;

  assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  assert_grant_is_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~ready_i) == '0);

endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int N_ENT    = 4,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 4,
  parameter int OP_W     = 4,
  parameter int IMM_W    = 16,
  parameter int BASE_TAG = 1,
  localparam int IDX_W   = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [DATA_W-1:0] iss_a_val,
  input  logic [TAG_W-1:0]  iss_a_tag,
  input  logic [DATA_W-1:0] iss_b_val,
  input  logic [TAG_W-1:0]  iss_b_tag,
  input  logic [IMM_W-1:0]  iss_imm,
  output logic [TAG_W-1:0]  iss_tag,
  output logic              full,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b,
  output logic [IMM_W-1:0]  disp_imm,
  output logic [TAG_W-1:0]  disp_tag
);

  logic [N_ENT-1:0] busy, ready, pick_oh, alloc_oh, grant;
  logic [IDX_W-1:0] pick_idx;
  logic             any_free, any_grant;

  logic [OP_W-1:0]   op_arr  [N_ENT];
  logic [DATA_W-1:0] a_arr   [N_ENT];
  logic [DATA_W-1:0] b_arr   [N_ENT];
  logic [IMM_W-1:0]  imm_arr [N_ENT];

  rs_alloc #(.N_ENT(N_ENT)) u_alloc (
    .busy_i     (busy),
    .pick_oh_o  (pick_oh),
    .pick_idx_o (pick_idx),
    .any_free_o (any_free)
  );

  assign iss_ready = any_free;
  assign full      = !any_free;
  assign iss_tag   = TAG_W'(BASE_TAG) + TAG_W'(pick_idx);
  assign alloc_oh  = (iss_valid && any_free) ? pick_oh : '0;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    rs_entry #(
      .DATA_W (DATA_W),
      .TAG_W  (TAG_W),
      .OP_W   (OP_W),
      .IMM_W  (IMM_W),
      .MY_TAG (TAG_W'(BASE_TAG + g))
    ) u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc_i  (alloc_oh[g]),
      .in_op    (iss_op),
      .in_a_val (iss_a_val),
      .in_a_tag (iss_a_tag),
      .in_b_val (iss_b_val),
      .in_b_tag (iss_b_tag),
      .in_imm   (iss_imm),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_data  (bc_data),
      .launch_i (grant[g] && disp_ready),
      .busy_o   (busy[g]),
      .ready_o  (ready[g]),
      .op_o     (op_arr[g]),
      .a_val_o  (a_arr[g]),
      .b_val_o  (b_arr[g]),
      .imm_o    (imm_arr[g])
    );
  end

  rs_age_sel #(.N_ENT(N_ENT)) u_sel (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_oh_i   (alloc_oh),
    .ready_i      (ready),
    .disp_ready_i (disp_ready),
    .grant_o      (grant),
    .any_o        (any_grant)
  );

  always_comb begin
    disp_op  = '0;
    disp_a   = '0;
    disp_b   = '0;
    disp_imm = '0;
    disp_tag = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (grant[i]) begin
        disp_op  = disp_op  | op_arr[i];
        disp_a   = disp_a   | a_arr[i];
        disp_b   = disp_b   | b_arr[i];
        disp_imm = disp_imm | imm_arr[i];
        disp_tag = disp_tag | (TAG_W'(BASE_TAG) + TAG_W'(i));
      end
    end
  end

  assign disp_valid = any_grant;

  assert_hold_offer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_tag) &&
      $stable(disp_op) && $stable(disp_a) && $stable(disp_b) && $stable(disp_imm)));

  assert_no_reselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |=> !(disp_valid && disp_tag == $past(disp_tag)));

endmodule

// File: tb/tb_rs_pool.sv
module tb_rs_pool;
  localparam int DW = 32;
  localparam int TW = 4;
  localparam int OW = 4;
  localparam int IW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iss_valid = 1'b0;
  logic          iss_ready;
  logic [OW-1:0] iss_op = '0;
  logic [DW-1:0] iss_a_val = '0, iss_b_val = '0;
  logic [TW-1:0] iss_a_tag = '0, iss_b_tag = '0;
  logic [IW-1:0] iss_imm = '0;
  logic [TW-1:0] iss_tag;
  logic          full;
  logic          bc_valid = 1'b0;
  logic [TW-1:0] bc_tag = '0;
  logic [DW-1:0] bc_data = '0;
  logic          disp_valid;
  logic          disp_ready = 1'b0;
  logic [OW-1:0] disp_op;
  logic [DW-1:0] disp_a, disp_b;
  logic [IW-1:0] disp_imm;
  logic [TW-1:0] disp_tag;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  rs_pool #(.N_ENT(4), .DATA_W(DW), .TAG_W(TW), .OP_W(OW), .IMM_W(IW), .BASE_TAG(1)) dut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
    .iss_a_val(iss_a_val), .iss_a_tag(iss_a_tag), .iss_b_val(iss_b_val),
    .iss_b_tag(iss_b_tag), .iss_imm(iss_imm), .iss_tag(iss_tag), .full(full),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
    .disp_a(disp_a), .disp_b(disp_b), .disp_imm(disp_imm), .disp_tag(disp_tag)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input string req, input logic [OW-1:0] op, input logic [DW-1:0] av,
                       input logic [TW-1:0] at, input logic [DW-1:0] bv,
                       input logic [TW-1:0] bt, input logic [TW-1:0] exp_tag);
    @(negedge clk);
    iss_op = op; iss_a_val = av; iss_a_tag = at; iss_b_val = bv; iss_b_tag = bt;
    iss_imm = {op, 12'h0ab};
    iss_valid = 1'b1;
    #1;
    chk(req, "iss_ready", iss_ready, 1);
    chk(req, "iss_tag", iss_tag, exp_tag);
    @(posedge clk);
    #1 iss_valid = 1'b0;
  endtask

  task automatic bcast(input logic [TW-1:0] t, input logic [DW-1:0] d);
    @(negedge clk);
    bc_valid = 1'b1; bc_tag = t; bc_data = d;
    @(posedge clk);
    #1 bc_valid = 1'b0;
  endtask

  task automatic take(input string req, input logic [TW-1:0] t, input logic [OW-1:0] op,
                      input logic [DW-1:0] a, input logic [DW-1:0] b);
    @(negedge clk);
    chk(req, "disp_valid", disp_valid, 1);
    chk(req, "disp_tag", disp_tag, t);
    chk(req, "disp_op", disp_op, op);
    chk(req, "disp_a", disp_a, a);
    chk(req, "disp_b", disp_b, b);
    chk(req, "disp_imm", disp_imm, {op, 12'h0ab});
    disp_ready = 1'b1;
    @(posedge clk);
    #1 disp_ready = 1'b0;
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    chk(req, "disp_valid idle", disp_valid, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "iss_ready", iss_ready, 1);
    chk("R1", "full", full, 0);
    chk("R1", "disp_valid", disp_valid, 0);
  endtask

  task automatic t_basic();
    issue("R2", 4'h3, 32'd10, 0, 32'd20, 0, 4'd1);
    take("R2", 4'd1, 4'h3, 32'd10, 32'd20);
    idle("R8");
    bcast(4'd1, 32'h1234);
    issue("R9", 4'h4, 32'd7, 0, 32'd8, 0, 4'd1);
    take("R9", 4'd1, 4'h4, 32'd7, 32'd8);
    bcast(4'd1, 32'h0);
  endtask

  task automatic t_wakeup();
    issue("R2", 4'h5, 32'hdead, 4'd9, 32'hbeef, 4'd10, 4'd1);
    idle("R4");
    bcast(4'd9, 32'haa);
    idle("R4");
    bcast(4'd10, 32'hbb);
    take("R5", 4'd1, 4'h5, 32'haa, 32'hbb);
    bcast(4'd1, 32'h0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    iss_op = 4'h6; iss_a_val = 32'h111; iss_a_tag = 4'd7; iss_b_val = 32'h3; iss_b_tag = 0;
    iss_imm = {4'h6, 12'h0ab};
    iss_valid = 1'b1;
    bc_valid = 1'b1; bc_tag = 4'd7; bc_data = 32'h55;
    @(posedge clk);
    #1 begin iss_valid = 1'b0; bc_valid = 1'b0; end
    take("R6", 4'd1, 4'h6, 32'h55, 32'h3);
    bcast(4'd1, 32'h0);
  endtask

  task automatic t_oldest();
    issue("R2", 4'h1, 32'd1, 0, 32'd2, 0, 4'd1);
    take("R7", 4'd1, 4'h1, 32'd1, 32'd2);
    issue("R2", 4'h2, 32'd0, 4'd9, 32'd4, 0, 4'd2);
    bcast(4'd1, 32'h0);
    issue("R9", 4'h7, 32'd0, 4'd9, 32'd6, 0, 4'd1);
    bcast(4'd9, 32'hd0);
    take("R7", 4'd2, 4'h2, 32'hd0, 32'd4);
    take("R7", 4'd1, 4'h7, 32'hd0, 32'd6);
    bcast(4'd2, 32'h0);
    bcast(4'd1, 32'h0);
  endtask

  task automatic t_lock();
    issue("R2", 4'h8, 32'd0, 4'd9, 32'd1, 0, 4'd1);
    issue("R2", 4'h9, 32'd5, 0, 32'd6, 0, 4'd2);
    @(negedge clk);
    chk("R8", "offer before wake", disp_tag, 4'd2);
    bcast(4'd9, 32'hee);
    take("R8", 4'd2, 4'h9, 32'd5, 32'd6);
    take("R8", 4'd1, 4'h8, 32'hee, 32'd1);
    bcast(4'd2, 32'h0);
    bcast(4'd1, 32'h0);
  endtask

  task automatic t_full();
    for (int i = 0; i < 4; i++)
      issue("R2", 4'(10 + i), 32'd0, 4'd9, 32'(i), 0, 4'(1 + i));
    @(negedge clk);
    chk("R3", "full", full, 1);
    chk("R3", "iss_ready", iss_ready, 0);
    iss_op = 4'hf; iss_a_val = 32'd1; iss_a_tag = 0; iss_b_val = 32'd1; iss_b_tag = 0;
    iss_valid = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R3", "disp_valid while full", disp_valid, 0);
    end
    iss_valid = 1'b0;
    bcast(4'd8, 32'h77);
    idle("R10");
    bcast(4'd3, 32'h66);
    @(negedge clk);
    chk("R9", "full kept", full, 1);
    bcast(4'd9, 32'h99);
    for (int i = 0; i < 4; i++)
      take("R7", 4'(1 + i), 4'(10 + i), 32'h99, 32'(i));
    idle("R3");
    for (int i = 0; i < 4; i++) bcast(4'(1 + i), 32'h0);
    @(negedge clk);
    chk("R9", "full cleared", full, 0);
    chk("R9", "iss_ready back", iss_ready, 1);
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_wakeup();
    t_same_cycle();
    t_oldest();
    t_lock();
    t_full();
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule